// File: doc/BRIEF.md
# PLL Control and Status Register with Lock Emulation

This block holds the control word of one PLL domain and models how that PLL reacts when the word changes. A host writes a 32-bit control word. The word carries a power-down flag, a bypass flag, three divider codes and a band field. The block turns the divider codes into the frequency the PLL would produce, working from a fixed parent frequency parameter. It reports that frequency as a binary code on `pll_rate`, in the same unit as the parent parameter.

Every control write drops the lock flag. The lock flag returns a programmable number of clock cycles later, unless the new word powers the PLL down. An error flag shows whether the intermediate (pre-output-divider) frequency falls outside a legal window set by parameters. Lock and error can also be read back through a registered read port, together with the stored control word.

The frequency is worked out by a serial restoring divider. The lock sequence runs in a four-state machine:
- `S_OFF`: powered down, unlocked. This is the state after reset.
- `S_CALC`: the divider is running.
- `S_WAIT`: the result is ready and the relock count is still running.
- `S_LOCKED`: locked.

The transitions are:
- write → `S_CALC`, from any state, and a write always wins.
- `S_CALC` → `S_OFF` when the divider finishes and power-down is set.
- `S_CALC` → `S_WAIT` when the divider finishes and the count is still running.
- `S_CALC` → `S_LOCKED` when the divider finishes and the count has already expired.
- `S_WAIT` → `S_LOCKED` when the count expires.

`S_OFF` and `S_LOCKED` hold until the next write. The divider has its own two-state machine: `D_IDLE` goes to `D_RUN` on start, and `D_RUN` returns to `D_IDLE` after its last step. A new start restarts it.

Top module: `pll_ctl_regs`

## Requirements
- R1: After reset the control word reads back as 0x00000001 (powered down, every divider code zero). Status reads 0, `pll_rate` is 0, and `pll_locked` and `pll_error` are low.
- R2: Address 0x0 reads the control word, with only bits 15:0 and 23:20 kept and every other bit read as 0. Address 0x4 reads status, with lock in bit 0, error in bit 1 and zeros elsewhere. Any other address reads 0. Read data appears in the cycle after `rd_en`.
- R3: A write to any address other than 0x0 changes neither the control word, nor lock, nor the rate.
- R4: The control word has these fields: bit 0 is power-down, bit 1 is bypass, bits 3:2 are the output code `od`, bits 8:4 are the input code `id`, and bits 15:9 are the feedback code `fb`. With bypass and power-down both clear, `pll_rate` = floor(PARENT_RATE·2·(fb+1) / ((id+1)·2^od)).
- R5: With bypass set, `pll_rate` equals PARENT_RATE whatever the power-down bit holds.
- R6: With power-down set and bypass clear, `pll_rate` is 0.
- R7: A write to address 0x0 makes `pll_locked` low after that clock edge. If power-down is clear, `pll_locked` rises exactly RELOCK_CYCLES clock edges after the write edge.
- R8: While the last control word written has power-down set, `pll_locked` stays low.
- R9: `pll_error` is high exactly when vco = floor(PARENT_RATE·2·(fb+1)/(id+1)) is below VCO_MIN or above VCO_MAX. It is judged on every control write, so a later write with a legal vco clears it.
- R10: A control write that lands while a relock is pending restarts the sequence. This includes a write on the very edge at which lock would have risen. Lock then rises RELOCK_CYCLES edges after the latest write, and the rate reflects the latest word.
- R11: `pll_rate` and `pll_error` take their new values no later than NUM_W+2 clock edges after the write edge, where NUM_W = RATE_W+9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 32 | Registered read data |
| pll_rate | output | RATE_W+9 | Output frequency code, in the unit of PARENT_RATE |
| pll_locked | output | 1 | Lock flag |
| pll_error | output | 1 | Intermediate frequency is outside the legal window |

## Verification
Two events can land on the same clock edge: a new control write, and either the end of the relock count or the divider finishing. The bench provokes this by issuing a second write on the exact edge at which lock would have risen, and a second write a few cycles into a pending relock. In both cases it expects `pll_locked` to stay low at that edge and to rise RELOCK_CYCLES edges after the second write, with the rate of the second word. A sweep over the input, feedback and output codes compares the rate and error against values computed arithmetically in the bench.

// File: rtl/pll_ctl_pkg.sv
package pll_ctl_pkg;

    // Control word field layout
    localparam int PD_BIT   = 0;
    localparam int BYP_BIT  = 1;
    localparam int OD_LSB   = 2;
    localparam int OD_W     = 2;
    localparam int ID_LSB   = 4;
    localparam int ID_W     = 5;
    localparam int FB_LSB   = 9;
    localparam int FB_W     = 7;
    localparam int BAND_LSB = 20;
    localparam int BAND_W   = 4;

    // Width of the low part of the control word that the decoder consumes
    localparam int LO_W = FB_LSB + FB_W;

    // Register byte addresses
    localparam int CTRL_ADDR = 0;
    localparam int STAT_ADDR = 4;

    // Bits of the control word that are stored; all others read back as zero
    localparam logic [31:0] CTRL_MASK =
        (32'(1) << LO_W) - 32'(1) | (((32'(1) << BAND_W) - 32'(1)) << BAND_LSB);

    // Control fields converted to their effective values
    typedef struct packed {
        logic            pd;
        logic            byp;
        logic [OD_W-1:0] od_sh;
        logic [ID_W:0]   in_div;
        logic [FB_W+1:0] fb_mul;
    } pll_cfg_t;

    typedef enum logic [1:0] {
        S_OFF,
        S_CALC,
        S_WAIT,
        S_LOCKED
    } lock_state_t;

    typedef enum logic {
        D_IDLE,
        D_RUN
    } div_state_t;

endpackage

// File: rtl/pll_field_decode.sv
module pll_field_decode
    import pll_ctl_pkg::*;
(
    input  logic [LO_W-1:0] ctrl_lo,
    output pll_cfg_t        cfg
);

    logic [FB_W:0] fb_plus1;

    always_comb begin
        fb_plus1    = {1'b0, ctrl_lo[FB_LSB +: FB_W]} + (FB_W+1)'(1);
        cfg.pd      = ctrl_lo[PD_BIT];
        cfg.byp     = ctrl_lo[BYP_BIT];
        cfg.od_sh   = ctrl_lo[OD_LSB +: OD_W];
        cfg.in_div  = {1'b0, ctrl_lo[ID_LSB +: ID_W]} + (ID_W+1)'(1);
        cfg.fb_mul  = {fb_plus1, 1'b0};
    end

endmodule

// File: rtl/pll_rate_divider.sv
module pll_rate_divider
    import pll_ctl_pkg::*;
#(
    parameter int NUM_W = 33,
    parameter int DEN_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quo
);

    localparam int CNT_W = $clog2(NUM_W);

    div_state_t       st;
    logic [CNT_W-1:0] steps_left;
    logic [DEN_W-1:0] rem;
    logic [DEN_W:0]   trial;
    logic             take;
    logic [DEN_W-1:0] rem_n;

    // One restoring step: bring down the next dividend bit, subtract if possible
    always_comb begin
        trial = {rem, quo[NUM_W-1]};
        take  = (trial >= {1'b0, den});
        rem_n = take ? DEN_W'(trial - {1'b0, den}) : trial[DEN_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st         <= D_IDLE;
            steps_left <= '0;
            rem        <= '0;
            quo        <= '0;
            done       <= 1'b0;
        end else if (start) begin
            st         <= D_RUN;
            steps_left <= CNT_W'(NUM_W - 1);
            rem        <= '0;
            quo        <= num;
            done       <= 1'b0;
        end else begin
            unique case (st)
                D_IDLE: begin
                    done <= 1'b0;
                end
                D_RUN: begin
                    rem <= rem_n;
                    quo <= {quo[NUM_W-2:0], take};
                    if (steps_left == '0) begin
                        st   <= D_IDLE;
                        done <= 1'b1;
                    end else begin
                        steps_left <= steps_left - CNT_W'(1);
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/pll_lock_fsm.sv
module pll_lock_fsm
    import pll_ctl_pkg::*;
#(
    parameter int RELOCK_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic pd,
    input  logic calc_done,
    output logic locked
);

    localparam int CW = $clog2(RELOCK_CYCLES + 1);

    lock_state_t st, st_n;
    logic [CW-1:0] cnt;
    logic          expired;

    assign expired = (cnt == '0);

    // Next state: a control write always restarts the sequence
    always_comb begin
        st_n = st;
        if (ctrl_wr) begin
            st_n = S_CALC;
        end else begin
            unique case (st)
                S_OFF:    st_n = S_OFF;
                S_CALC: begin
                    if (calc_done) begin
                        if (pd)           st_n = S_OFF;
                        else if (expired) st_n = S_LOCKED;
                        else              st_n = S_WAIT;
                    end
                end
                S_WAIT:   if (expired) st_n = S_LOCKED;
                S_LOCKED: st_n = S_LOCKED;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_OFF;
        else        st <= st_n;
    end

    // Relock counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt <= '0;
        else if (ctrl_wr)  cnt <= CW'(RELOCK_CYCLES - 1);
        else if (!expired) cnt <= cnt - CW'(1);
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) locked <= 1'b0;
        else        locked <= (st_n == S_LOCKED);
    end

endmodule

// File: rtl/pll_ctl_regs.sv
module pll_ctl_regs
    import pll_ctl_pkg::*;
#(
    parameter int unsigned PARENT_RATE   = 33333,
    parameter int          RATE_W        = 24,
    parameter int          RELOCK_CYCLES = 64,
    parameter int unsigned VCO_MIN       = 400000,
    parameter int unsigned VCO_MAX       = 1600000,
    parameter int          ADDR_W        = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [31:0]          wr_data,
    input  logic                 rd_en,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [31:0]          rd_data,
    output logic [RATE_W+8:0]    pll_rate,
    output logic                 pll_locked,
    output logic                 pll_error
);

    localparam int NUM_W = RATE_W + FB_W + 2;
    localparam int DEN_W = ID_W + 1;
    localparam logic [NUM_W-1:0] PARENT_V = NUM_W'(PARENT_RATE);
    localparam logic [NUM_W-1:0] VMIN_V   = NUM_W'(VCO_MIN);
    localparam logic [NUM_W-1:0] VMAX_V   = NUM_W'(VCO_MAX);

    logic [31:0]      ctrl_q;
    logic             ctrl_wr;
    logic             start_q;
    pll_cfg_t         cfg;
    logic [NUM_W-1:0] num;
    logic             div_done;
    logic [NUM_W-1:0] vco;
    logic             calc_done;

    assign ctrl_wr   = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
    assign num       = PARENT_V * NUM_W'(cfg.fb_mul);
    assign calc_done = div_done && !start_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= 32'(1) << PD_BIT;
            start_q <= 1'b0;
        end else begin
            start_q <= ctrl_wr;
            if (ctrl_wr) ctrl_q <= wr_data & CTRL_MASK;
        end
    end

    pll_field_decode u_dec (
        .ctrl_lo (ctrl_q[LO_W-1:0]),
        .cfg     (cfg)
    );

    pll_rate_divider #(
        .NUM_W (NUM_W),
        .DEN_W (DEN_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start_q),
        .num   (num),
        .den   (cfg.in_div),
        .done  (div_done),
        .quo   (vco)
    );

    pll_lock_fsm #(
        .RELOCK_CYCLES (RELOCK_CYCLES)
    ) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .pd        (cfg.pd),
        .calc_done (calc_done),
        .locked    (pll_locked)
    );

    // Result registers, loaded when a computation for the current word finishes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pll_rate  <= '0;
            pll_error <= 1'b0;
        end else if (calc_done) begin
            if (cfg.byp)     pll_rate <= PARENT_V;
            else if (cfg.pd) pll_rate <= '0;
            else             pll_rate <= vco >> cfg.od_sh;
            pll_error <= (vco < VMIN_V) || (vco > VMAX_V);
        end
    end

    // Registered read port
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            if (rd_addr == ADDR_W'(CTRL_ADDR))      rd_data <= ctrl_q;
            else if (rd_addr == ADDR_W'(STAT_ADDR)) rd_data <= {30'b0, pll_error, pll_locked};
            else                                    rd_data <= '0;
        end
    end

endmodule

// File: rtl/pll_ctl_regs_chk.sv
module pll_ctl_regs_chk
    import pll_ctl_pkg::*;
#(
    parameter int unsigned PARENT_RATE   = 33333,
    parameter int          RATE_W        = 24,
    parameter int          RELOCK_CYCLES = 64,
    parameter int          ADDR_W        = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [1:0]        wr_mode,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [31:0]       rd_data,
    input logic [RATE_W+8:0] pll_rate,
    input logic              pll_locked
);

    localparam int NUM_W  = RATE_W + 9;
    localparam int SW     = $clog2(RELOCK_CYCLES + NUM_W + 8) + 1;
    localparam logic [SW-1:0] SMAX   = {SW{1'b1}};
    localparam logic [SW-1:0] SETTLE = SW'(NUM_W + 2);

    logic          ctrl_wr;
    logic [SW-1:0] since_wr;
    logic          last_pd;
    logic          last_byp;
    logic          odd_rd;

    assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
    assign odd_rd  = rd_en && (rd_addr != ADDR_W'(CTRL_ADDR)) && (rd_addr != ADDR_W'(STAT_ADDR));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_wr <= SMAX;
            last_pd  <= 1'b1;
            last_byp <= 1'b0;
        end else if (ctrl_wr) begin
            since_wr <= '0;
            last_pd  <= wr_mode[PD_BIT];
            last_byp <= wr_mode[BYP_BIT];
        end else if (since_wr != SMAX) begin
            since_wr <= since_wr + SW'(1);
        end
    end

    // R2
    unused_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        odd_rd |=> (rd_data == 32'd0));

    // R7
    write_drops_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> !pll_locked);

    // R7
    relock_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_locked) |-> (since_wr == SW'(RELOCK_CYCLES)));

    // R8
    pd_no_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_pd |-> !pll_locked);

    // R5
    bypass_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_byp && since_wr > SETTLE) |-> (pll_rate == NUM_W'(PARENT_RATE)));

    // R6
    pd_rate_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_pd && !last_byp && since_wr > SETTLE) |-> (pll_rate == '0));

endmodule

bind pll_ctl_regs pll_ctl_regs_chk #(
    .PARENT_RATE   (PARENT_RATE),
    .RATE_W        (RATE_W),
    .RELOCK_CYCLES (RELOCK_CYCLES),
    .ADDR_W        (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_mode    (wr_data[1:0]),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .pll_rate   (pll_rate),
    .pll_locked (pll_locked)
);

// File: tb/pll_ctl_regs_test.sv
module pll_ctl_regs_test;

    localparam int    PARENT = 33333;
    localparam int    RATE_W = 24;
    localparam int    RELOCK = 64;
    localparam int    VMIN   = 400000;
    localparam int    VMAX   = 1600000;
    localparam int    DW     = RATE_W + 9;
    localparam time   TCLK   = 20ns;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [3:0]        wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic              rd_en = 1'b0;
    logic [3:0]        rd_addr = '0;
    logic [31:0]       rd_data;
    logic [RATE_W+8:0] pll_rate;
    logic              pll_locked;
    logic              pll_error;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    always #(TCLK/2) clk = ~clk;

    pll_ctl_regs #(
        .PARENT_RATE   (PARENT),
        .RATE_W        (RATE_W),
        .RELOCK_CYCLES (RELOCK),
        .VCO_MIN       (VMIN),
        .VCO_MAX       (VMAX),
        .ADDR_W        (4)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .pll_rate   (pll_rate),
        .pll_locked (pll_locked),
        .pll_error  (pll_error)
    );

    function automatic longint vco_of(int w);
        longint id = (w >> 4) & 31;
        longint fb = (w >> 9) & 127;
        return (longint'(PARENT) * 2 * (fb + 1)) / (id + 1);
    endfunction

    function automatic longint rate_of(int w);
        if (w & 2) return PARENT;
        if (w & 1) return 0;
        return vco_of(w) >> ((w >> 2) & 3);
    endfunction

    function automatic longint err_of(int w);
        return (vco_of(w) < VMIN || vco_of(w) > VMAX) ? 1 : 0;
    endfunction

    task automatic chk(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_write(int addr, int data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 4'(addr);
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic do_read(int addr, output longint val);
        @(negedge clk);
        rd_en   = 1'b1;
        rd_addr = 4'(addr);
        @(negedge clk);
        rd_en   = 1'b0;
        val     = rd_data;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        longint v;
        int w1, w2, w3, wbad;
        w1   = (11 << 9) | (0 << 4) | (1 << 2);
        w2   = (47 << 9) | (1 << 4) | (3 << 2);
        w3   = 2;
        wbad = (127 << 9);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 rate", pll_rate, 0);
        chk("R1 lock", pll_locked, 0);
        chk("R1 error", pll_error, 0);
        do_read(0, v);  chk("R1 ctrl", v, 1);
        do_read(4, v);  chk("R1 status", v, 0);

        // R2 masking, R5 bypass over power-down, R8, R9 via status
        do_write(0, 32'hFFFF_FFFF);
        repeat (RELOCK + 4) @(negedge clk);
        do_read(0, v);  chk("R2 ctrl mask", v, 32'h00F0_FFFF);
        do_read(8, v);  chk("R2 unused addr", v, 0);
        chk("R5 bypass with pd", pll_rate, PARENT);
        chk("R8 pd keeps unlocked", pll_locked, 0);
        do_read(4, v);  chk("R9 status error", v, err_of(32'h00F0_FFFF) << 1);

        // R6 power-down only
        do_write(0, 1 | (11 << 9) | (3 << 2));
        repeat (RELOCK + 4) @(negedge clk);
        chk("R6 pd rate", pll_rate, 0);
        chk("R8 pd lock", pll_locked, 0);

        // R7 exact relock timing
        do_write(0, w1);
        repeat (RELOCK - 1) @(negedge clk);
        chk("R7 not yet locked", pll_locked, 0);
        @(negedge clk);
        chk("R7 locked on time", pll_locked, 1);
        chk("R4 rate w1", pll_rate, rate_of(w1));

        // R7 drop, R11 result timing
        do_write(0, w2);
        chk("R7 lock dropped", pll_locked, 0);
        repeat (DW + 2) @(negedge clk);
        chk("R11 rate ready", pll_rate, rate_of(w2));
        chk("R11 error ready", pll_error, err_of(w2));
        repeat (RELOCK - DW - 2) @(negedge clk);
        chk("R7 relocked w2", pll_locked, 1);

        // R3 writes elsewhere ignored
        do_write(4, 32'hFFFF_FFFF);
        do_write(12, 0);
        chk("R3 lock kept", pll_locked, 1);
        chk("R3 rate kept", pll_rate, rate_of(w2));
        do_read(0, v);  chk("R3 ctrl kept", v, w2);

        // R10 write during pending relock
        do_write(0, w1);
        repeat (10) @(negedge clk);
        do_write(0, w3);
        repeat (RELOCK - 1) @(negedge clk);
        chk("R10 restart not yet", pll_locked, 0);
        @(negedge clk);
        chk("R10 restart locked", pll_locked, 1);
        chk("R10 latest rate", pll_rate, PARENT);

        // R10 write on the expiry edge
        do_write(0, w1);
        repeat (RELOCK - 2) @(negedge clk);
        do_write(0, w2);
        chk("R10 expiry edge stays low", pll_locked, 0);
        repeat (RELOCK - 1) @(negedge clk);
        chk("R10 expiry not yet", pll_locked, 0);
        @(negedge clk);
        chk("R10 expiry relocked", pll_locked, 1);
        chk("R10 expiry rate", pll_rate, rate_of(w2));

        // R9 set then clear
        do_write(0, wbad);
        repeat (RELOCK) @(negedge clk);
        chk("R9 error set", pll_error, 1);
        do_write(0, w1);
        repeat (RELOCK) @(negedge clk);
        chk("R9 error cleared", pll_error, 0);

        // R4 R9 sweep over divider codes
        for (int id = 0; id < 32; id += 3) begin
            for (int fb = 0; fb < 128; fb += 9) begin
                for (int od = 0; od < 4; od++) begin
                    int w;
                    w = (fb << 9) | (id << 4) | (od << 2);
                    do_write(0, w);
                    repeat (RELOCK) @(negedge clk);
                    chk("R4 sweep rate", pll_rate, rate_of(w));
                    chk("R9 sweep error", pll_error, err_of(w));
                    chk("R7 sweep lock", pll_locked, 1);
                end
            end
        end

        finish_run();
    end

endmodule